// File: doc/BRIEF.md
# Programmable Three-Channel Interval Timer

This block is a port-mapped timer that sits on an 8-bit processor data bus. It has three independent 16-bit down-counters. Each counter advances only in cycles where its own count-enable input is high, and each drives one output pin. The block decodes its own chip select from the upper bits of a 10-bit port address. The two lowest address bits pick one of the three counters or the shared control port. Reads and writes are single-cycle strobes that are sampled on the rising clock edge.

A control byte written to the control port reprograms one counter. It sets how count bytes are transferred (low byte only, high byte only, or low then high), the operating mode, and whether the counter counts in binary or in four BCD digits. The same port also takes a snapshot command, which freezes a copy of a live count so that it can be read back coherently. The three supported modes are:
- a one-shot that raises its output at terminal count;
- a divide-by-N rate generator;
- a square-wave generator.

Top module: `tri_timer`

## Requirements
- R1: The block responds only to port addresses whose bits 9..2 equal those of the base port 0x40. Address bits 1..0 select counter 0 (00), counter 1 (01), counter 2 (10) or the control port (11). Any access outside the window changes no state and leaves `data_oe` low.
- R2: The control byte has these fields: counter select in bits 7:6 (00, 01, 10; the value 11 is ignored), transfer order in bits 5:4, mode in bits 3:1 (000 one-shot, 010 or 110 rate, 011 or 111 square), and BCD in bit 0. For example, writing 0xB6 and then 0x34, 0x12 to counter 2 gives a binary square wave with a count of 0x1234.
- R3: Transfer order 01 moves the low byte only and 10 moves the high byte only; the other byte reads as zero. Order 11 moves the low byte first and then the high byte. A new count is loaded on the first enabled cycle after the final byte is written, not before.
- R4: Writing transfer order 00 takes a snapshot of the selected counter's live count. A second snapshot command is ignored while the first is still unread. Reads return the snapshot until the full byte sequence has been read.
- R5: Once no snapshot is pending, reads return the live count in the configured byte order, and each read advances the read byte pointer.
- R6: A loaded count of zero acts as the largest count: 65536 in binary, 10000 in BCD. Its first decrement gives 0xFFFF or 0x9999 respectively.
- R7: In BCD mode each 4-bit digit counts down from 0 to 9 and borrows from the next digit (0x1000 decrements to 0x0999).
- R8: In one-shot mode the output goes low when the control byte is written and again when a new count completes. It goes high on the enable that brings the count to zero and stays high while the counter keeps wrapping.
- R9: In rate mode with count N, the output is low for exactly one enabled cycle out of every N, namely while the count equals 1. The count then reloads to N.
- R10: In square mode with count N, the output is high for ceil(N/2) enabled cycles and low for floor(N/2).
- R11: Reads or writes with both strobes high, or with the address outside the window, have no effect and keep `data_oe` low. Reading the control port also leaves `data_oe` low.
- R12: A control byte that reprograms a counter resets both its write and read byte pointers to the low byte and stops the counter until a new count is loaded.
- R13: A counter's value does not change in any cycle where its enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | 10 | Port address |
| rd_stb | input | 1 | Read strobe, one cycle per byte |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| data_in | input | 8 | Write data |
| data_out | output | 8 | Read data, valid while `data_oe` is high |
| data_oe | output | 1 | Read data drive enable |
| cnt_en | input | 3 | Per-counter count enable |
| tmr_out | output | 3 | Per-counter output |

## Verification
The hardest state to reach from the ports is a snapshot that is held across a partial read while the live count keeps moving. To reach it, the bench first loads a count whose high byte changes while the read is incomplete. It then issues a snapshot, advances the counter, reads only the low byte, and sends a second, ignored snapshot command. Reading the high byte must then return the frozen byte and not the live one. The long terminal windows (65536 enables, and half of 0x1234 in square mode) are driven with continuous enable bursts, and the output is checked one enable before and one enable after each edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CW  = 16;
    localparam int ND  = CW / 4;
    localparam int NCH = 3;

    typedef enum logic [1:0] {
        ACC_SNAP = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_BOTH = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        RUN_TERM,
        RUN_RATE,
        RUN_SQUARE,
        RUN_IDLE
    } run_e;

    typedef struct packed {
        acc_e acc;
        run_e run;
        logic bcd;
    } chan_cfg_t;

    function automatic run_e decode_mode(input logic [2:0] m);
        if (m == 3'b000)        return RUN_TERM;
        else if (m[1:0] == 2'b10) return RUN_RATE;
        else if (m[1:0] == 2'b11) return RUN_SQUARE;
        else                    return RUN_IDLE;
    endfunction

    function automatic logic [CW-1:0] count_dec(input logic [CW-1:0] v, input logic bcd);
        logic [CW-1:0] r;
        logic borrow;
        if (!bcd) return v - 1'b1;
        r = v;
        borrow = 1'b1;
        for (int d = 0; d < ND; d++) begin
            if (borrow) begin
                if (v[4*d +: 4] == 4'd0) r[4*d +: 4] = 4'd9;
                else begin
                    r[4*d +: 4] = v[4*d +: 4] - 4'd1;
                    borrow = 1'b0;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [CW-1:0] count_half(input logic [CW-1:0] v, input logic bcd);
        logic [CW-1:0] r;
        logic odd;
        if (v == '0) return bcd ? {4'h5, {(CW-4){1'b0}}} : {1'b1, {(CW-1){1'b0}}};
        if (!bcd) return v >> 1;
        r = '0;
        odd = 1'b0;
        for (int d = ND - 1; d >= 0; d--) begin
            r[4*d +: 4] = (v[4*d +: 4] >> 1) + (odd ? 4'd5 : 4'd0);
            odd = v[4*d];
        end
        return r;
    endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
    parameter int AW = 10,
    parameter logic [AW-1:0] BASE = 10'h040
) (
    input  logic [AW-1:0] port_addr,
    input  logic          rd_stb,
    input  logic          wr_stb,
    output logic [1:0]    reg_sel,
    output logic          wr_go,
    output logic          rd_go
);
    logic hit;

    assign hit     = (port_addr[AW-1:2] == BASE[AW-1:2]);
    assign reg_sel = port_addr[1:0];
    assign wr_go   = hit && wr_stb && !rd_stb;
    assign rd_go   = hit && rd_stb && !wr_stb;
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  logic          cnt_wr,
    input  logic          cnt_rd,
    input  logic [7:0]    din,
    input  logic [CW-1:0] live,
    output run_e          run,
    output logic          bcd,
    output logic          cfg_new,
    output run_e          nxt_run,
    output logic          load_go,
    output logic [CW-1:0] reload,
    output logic [7:0]    dout
);
    chan_cfg_t     cfg_q;
    logic          wr_tog, rd_tog, latched;
    logic [CW-1:0] latch_q, src;
    logic [7:0]    lo_hold;
    logic          pick_hi;

    assign run     = cfg_q.run;
    assign bcd     = cfg_q.bcd;
    assign cfg_new = ctrl_wr && (din[5:4] != 2'b00);
    assign nxt_run = decode_mode(din[3:1]);
    assign load_go = cnt_wr && (cfg_q.acc != ACC_BOTH || wr_tog);

    assign src     = latched ? latch_q : live;
    assign pick_hi = (cfg_q.acc == ACC_HI) || (cfg_q.acc == ACC_BOTH && rd_tog);
    assign dout    = pick_hi ? src[15:8] : src[7:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{acc: ACC_BOTH, run: RUN_TERM, bcd: 1'b0};
            wr_tog  <= 1'b0;
            rd_tog  <= 1'b0;
            latched <= 1'b0;
            latch_q <= '0;
            lo_hold <= '0;
            reload  <= '0;
        end else if (ctrl_wr) begin
            if (din[5:4] == 2'b00) begin
                if (!latched) begin
                    latched <= 1'b1;
                    latch_q <= live;
                end
            end else begin
                cfg_q   <= '{acc: acc_e'(din[5:4]), run: decode_mode(din[3:1]), bcd: din[0]};
                wr_tog  <= 1'b0;
                rd_tog  <= 1'b0;
                latched <= 1'b0;
            end
        end else begin
            if (cnt_wr) begin
                case (cfg_q.acc)
                    ACC_LO:  reload <= {8'h00, din};
                    ACC_HI:  reload <= {din, 8'h00};
                    default: begin
                        if (wr_tog) reload <= {din, lo_hold};
                        else        lo_hold <= din;
                        wr_tog <= !wr_tog;
                    end
                endcase
            end
            if (cnt_rd) begin
                if (cfg_q.acc == ACC_BOTH) begin
                    rd_tog <= !rd_tog;
                    if (rd_tog) latched <= 1'b0;
                end else begin
                    latched <= 1'b0;
                end
            end
        end
    end

    p_ptr_clear_r12: assert property (@(posedge clk) disable iff (rst)
        cfg_new |=> (!wr_tog && !rd_tog));

    p_snap_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (latched && !cnt_rd && !cfg_new) |=> (latched && $stable(latch_q)));
endmodule

// File: rtl/tmr_chan_core.sv
module tmr_chan_core
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  run_e          run,
    input  logic          bcd,
    input  logic          cfg_new,
    input  run_e          nxt_run,
    input  logic          load_go,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] count,
    output logic          out
);
    logic          pend, running;
    logic [CW-1:0] half_w, dec_w;
    logic          sq_term;

    assign half_w  = count_half(reload, bcd);
    assign dec_w   = count_dec(count, bcd);
    assign sq_term = (out && reload[0]) ? (count == '0) : (count == 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            out     <= 1'b0;
            pend    <= 1'b0;
            running <= 1'b0;
        end else if (cfg_new) begin
            pend    <= 1'b0;
            running <= 1'b0;
            out     <= (nxt_run != RUN_TERM);
        end else begin
            if (en) begin
                if (pend) begin
                    pend    <= 1'b0;
                    running <= 1'b1;
                    count   <= (run == RUN_SQUARE) ? half_w : reload;
                    out     <= (run != RUN_TERM);
                end else if (running) begin
                    case (run)
                        RUN_TERM: begin
                            count <= dec_w;
                            if (count == 1) out <= 1'b1;
                        end
                        RUN_RATE: begin
                            if (count == 1) begin
                                count <= reload;
                                out   <= 1'b1;
                            end else begin
                                count <= dec_w;
                                out   <= (count != 2);
                            end
                        end
                        RUN_SQUARE: begin
                            if (sq_term) begin
                                out   <= !out;
                                count <= half_w;
                            end else begin
                                count <= dec_w;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            if (load_go) begin
                pend <= 1'b1;
                if (run == RUN_TERM) out <= 1'b0;
            end
        end
    end

    p_hold_no_en_r13: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count));

    p_term_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (run == RUN_TERM && out && !cfg_new && !load_go) |=> out);

    p_rate_one_low_r9: assert property (@(posedge clk) disable iff (rst)
        (run == RUN_RATE && !out && en && !cfg_new) |=> out);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       ctrl_wr,
    input  logic       cnt_wr,
    input  logic       cnt_rd,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       out
);
    run_e          run, nxt_run;
    logic          bcd, cfg_new, load_go;
    logic [CW-1:0] reload, count;

    tmr_chan_port u_port (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .cnt_rd(cnt_rd),
        .din(din), .live(count), .run(run), .bcd(bcd), .cfg_new(cfg_new),
        .nxt_run(nxt_run), .load_go(load_go), .reload(reload), .dout(dout)
    );

    tmr_chan_core u_core (
        .clk(clk), .rst(rst), .en(en), .run(run), .bcd(bcd), .cfg_new(cfg_new),
        .nxt_run(nxt_run), .load_go(load_go), .reload(reload), .count(count), .out(out)
    );
endmodule

// File: rtl/tri_timer.sv
module tri_timer
    import tmr_pkg::*;
#(
    parameter int AW = 10,
    parameter logic [AW-1:0] BASE = 10'h040
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  port_addr,
    input  logic           rd_stb,
    input  logic           wr_stb,
    input  logic [7:0]     data_in,
    output logic [7:0]     data_out,
    output logic           data_oe,
    input  logic [NCH-1:0] cnt_en,
    output logic [NCH-1:0] tmr_out
);
    localparam logic [1:0] CTRL_SEL = 2'b11;

    logic [1:0]     reg_sel;
    logic           wr_go, rd_go;
    logic [NCH-1:0] ctrl_wr, cnt_wr, cnt_rd;
    logic [7:0]     ch_dout [NCH];

    tmr_decode #(.AW(AW), .BASE(BASE)) u_dec (
        .port_addr(port_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .reg_sel(reg_sel), .wr_go(wr_go), .rd_go(rd_go)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ctrl_wr[g] = wr_go && reg_sel == CTRL_SEL && data_in[7:6] == 2'(g);
        assign cnt_wr[g]  = wr_go && reg_sel == 2'(g);
        assign cnt_rd[g]  = rd_go && reg_sel == 2'(g);

        tmr_channel u_ch (
            .clk(clk), .rst(rst), .en(cnt_en[g]), .ctrl_wr(ctrl_wr[g]),
            .cnt_wr(cnt_wr[g]), .cnt_rd(cnt_rd[g]), .din(data_in),
            .dout(ch_dout[g]), .out(tmr_out[g])
        );
    end

    assign data_oe = rd_go && reg_sel != CTRL_SEL;

    always_comb begin
        data_out = '0;
        for (int i = 0; i < NCH; i++)
            if (data_oe && reg_sel == 2'(i)) data_out = ch_dout[i];
    end

    p_oe_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        ((rd_stb && wr_stb) || port_addr[AW-1:2] != BASE[AW-1:2]) |-> !data_oe);
endmodule

// File: tb/tri_timer_bench.sv
module tri_timer_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] port_addr = '0;
    logic       rd_stb = 1'b0, wr_stb = 1'b0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;
    logic [2:0] cnt_en = '0;
    logic [2:0] tmr_out;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    tri_timer u_tri_timer (
        .clk(clk), .rst(rst), .port_addr(port_addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .cnt_en(cnt_en), .tmr_out(tmr_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_port(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk); port_addr = a; data_in = d; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic wr_both(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk); port_addr = a; data_in = d; wr_stb = 1'b1; rd_stb = 1'b1;
        #1; chk(!data_oe, "R11 oe with both strobes", data_oe, 0);
        @(negedge clk); wr_stb = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic rd_port(input logic [9:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk); port_addr = a; rd_stb = 1'b1;
        #1; d = data_out; oe = data_oe;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic rd16(input int ch, output logic [15:0] v);
        logic [7:0] lo, hi;
        logic oe;
        rd_port(10'h040 + 10'(ch), lo, oe);
        rd_port(10'h040 + 10'(ch), hi, oe);
        v = {hi, lo};
    endtask

    task automatic pulse(input logic [2:0] m, input int n);
        @(negedge clk); cnt_en = m;
        repeat (n) @(negedge clk);
        cnt_en = '0;
    endtask

    task automatic t_reset;
        logic [7:0] d; logic oe;
        chk(tmr_out == 3'b000, "R8 reset outputs", tmr_out, 0);
        chk(!data_oe, "R11 idle oe", data_oe, 0);
        rd_port(10'h040, d, oe);
        chk(oe && d == 8'h00, "R5 reset count read", {oe, d}, 9'h100);
    endtask

    task automatic t_sequencing;
        logic [15:0] v;
        wr_port(10'h043, 8'h30);
        wr_port(10'h040, 8'h34);
        pulse(3'b001, 1);
        rd16(0, v); chk(v == 16'h0000, "R3 no load after LSB only", v, 16'h0000);
        wr_port(10'h040, 8'h12);
        rd16(0, v); chk(v == 16'h0000, "R3 no load before enable", v, 16'h0000);
        pulse(3'b001, 1);
        rd16(0, v); chk(v == 16'h1234, "R3 load LSB then MSB", v, 16'h1234);
        pulse(3'b010, 3);
        rd16(0, v); chk(v == 16'h1234, "R13 hold without enable", v, 16'h1234);
        pulse(3'b001, 1);
        rd16(0, v); chk(v == 16'h1233, "R5 live read after decrement", v, 16'h1233);
    endtask

    task automatic t_oneshot;
        logic [7:0] d; logic oe;
        wr_port(10'h043, 8'h10);
        chk(tmr_out[0] == 1'b0, "R8 low after control", tmr_out[0], 0);
        wr_port(10'h040, 8'h03);
        pulse(3'b001, 1);
        chk(tmr_out[0] == 1'b0, "R8 low after load", tmr_out[0], 0);
        pulse(3'b001, 2);
        chk(tmr_out[0] == 1'b0, "R8 low at count 1", tmr_out[0], 0);
        pulse(3'b001, 1);
        chk(tmr_out[0] == 1'b1, "R8 high at zero", tmr_out[0], 1);
        pulse(3'b001, 3);
        chk(tmr_out[0] == 1'b1, "R8 stays high", tmr_out[0], 1);
        rd_port(10'h040, d, oe);
        chk(d == 8'hFD, "R3 LSB-only read after wrap", d, 8'hFD);
    endtask

    task automatic t_snapshot;
        logic [7:0] d; logic oe; logic [15:0] v;
        wr_port(10'h043, 8'h70);
        wr_port(10'h041, 8'h05);
        wr_port(10'h041, 8'h03);
        pulse(3'b010, 1);
        pulse(3'b010, 5);
        wr_port(10'h043, 8'h40);
        pulse(3'b010, 3);
        rd_port(10'h041, d, oe);
        chk(d == 8'h00, "R4 snapshot low byte", d, 8'h00);
        wr_port(10'h043, 8'h40);
        pulse(3'b010, 2);
        rd_port(10'h041, d, oe);
        chk(d == 8'h03, "R4 snapshot high byte frozen", d, 8'h03);
        rd16(1, v);
        chk(v == 16'h02FB, "R5 live after snapshot read", v, 16'h02FB);
    endtask

    task automatic t_rate;
        wr_port(10'h043, 8'h54);
        wr_port(10'h041, 8'h04);
        pulse(3'b010, 1);
        chk(tmr_out[1] == 1'b1, "R9 high after load", tmr_out[1], 1);
        for (int k = 1; k <= 8; k++) begin
            pulse(3'b010, 1);
            chk(tmr_out[1] == (k % 4 != 3), "R9 rate output", tmr_out[1], (k % 4 != 3));
        end
    endtask

    task automatic t_square;
        wr_port(10'h043, 8'h96);
        wr_port(10'h042, 8'h05);
        pulse(3'b100, 1);
        for (int k = 1; k <= 10; k++) begin
            pulse(3'b100, 1);
            chk(tmr_out[2] == !(k % 5 == 3 || k % 5 == 4), "R10 odd square", tmr_out[2],
                !(k % 5 == 3 || k % 5 == 4));
        end
        wr_port(10'h042, 8'h04);
        pulse(3'b100, 1);
        for (int k = 1; k <= 8; k++) begin
            pulse(3'b100, 1);
            chk(tmr_out[2] == (k % 4 <= 1), "R10 even square", tmr_out[2], (k % 4 <= 1));
        end
    endtask

    task automatic t_example;
        wr_port(10'h043, 8'hB6);
        wr_port(10'h042, 8'h34);
        wr_port(10'h042, 8'h12);
        pulse(3'b100, 1);
        chk(tmr_out[2] == 1'b1, "R2 square high after load", tmr_out[2], 1);
        pulse(3'b100, 2329);
        chk(tmr_out[2] == 1'b1, "R2 high through half period", tmr_out[2], 1);
        pulse(3'b100, 1);
        chk(tmr_out[2] == 1'b0, "R2 low after 2330 enables", tmr_out[2], 0);
    endtask

    task automatic t_zero_max;
        logic [15:0] v;
        wr_port(10'h043, 8'h30);
        wr_port(10'h040, 8'h00);
        wr_port(10'h040, 8'h00);
        pulse(3'b001, 1);
        pulse(3'b001, 1);
        rd16(0, v); chk(v == 16'hFFFF, "R6 binary zero decrement", v, 16'hFFFF);
        pulse(3'b001, 65534);
        chk(tmr_out[0] == 1'b0, "R6 low before 65536", tmr_out[0], 0);
        pulse(3'b001, 1);
        chk(tmr_out[0] == 1'b1, "R6 high at 65536", tmr_out[0], 1);
    endtask

    task automatic t_bcd;
        logic [15:0] v;
        wr_port(10'h043, 8'h71);
        wr_port(10'h041, 8'h00);
        wr_port(10'h041, 8'h00);
        pulse(3'b010, 2);
        rd16(1, v); chk(v == 16'h9999, "R6 BCD zero decrement", v, 16'h9999);
        wr_port(10'h041, 8'h00);
        wr_port(10'h041, 8'h10);
        pulse(3'b010, 2);
        rd16(1, v); chk(v == 16'h0999, "R7 BCD borrow", v, 16'h0999);
        pulse(3'b010, 1);
        rd16(1, v); chk(v == 16'h0998, "R7 BCD digit step", v, 16'h0998);
    endtask

    task automatic t_ignore;
        logic [7:0] d; logic oe; logic [15:0] v;
        wr_port(10'h043, 8'h30);
        wr_port(10'h040, 8'h10);
        wr_port(10'h040, 8'h00);
        pulse(3'b001, 1);
        wr_port(10'h180, 8'h55);
        wr_port(10'h1C3, 8'h10);
        wr_both(10'h040, 8'h77);
        wr_both(10'h043, 8'h10);
        rd_port(10'h180, d, oe);
        chk(!oe, "R1 oe outside window", oe, 0);
        rd_port(10'h043, d, oe);
        chk(!oe, "R11 oe on control read", oe, 0);
        pulse(3'b001, 1);
        rd16(0, v);
        chk(v == 16'h000F, "R11 ignored accesses", v, 16'h000F);
    endtask

    task automatic t_ptr_reset;
        logic [7:0] d; logic oe; logic [15:0] v;
        wr_port(10'h043, 8'h30);
        wr_port(10'h040, 8'hAA);
        wr_port(10'h043, 8'h30);
        wr_port(10'h040, 8'h05);
        wr_port(10'h040, 8'h00);
        pulse(3'b001, 1);
        rd16(0, v); chk(v == 16'h0005, "R12 write pointer reset", v, 16'h0005);
        rd_port(10'h040, d, oe);
        wr_port(10'h043, 8'h30);
        pulse(3'b001, 2);
        rd_port(10'h040, d, oe);
        chk(d == 8'h05, "R12 read pointer reset and stop", d, 8'h05);
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sequencing();
        t_oneshot();
        t_snapshot();
        t_rate();
        t_square();
        t_example();
        t_zero_max();
        t_bcd();
        t_ignore();
        t_ptr_reset();
        finish_run();
    end
endmodule